// File: doc/BRIEF.md
# Prioritized Peripheral Interrupt Controller

This block gathers level-sensitive requests from a set of on-chip peripheral sources and presents them to a processor core on two lines: a normal interrupt line and a fast interrupt line. Software reaches it through a simple word-wide register bus. Through that bus it enables sources one by one, chooses the line each source drives, and fills a priority table. Each entry of the table names one source.

The controller continuously works out the enabled pending set. It also searches the priority table for the most urgent pending source and publishes the result in a highest-priority register, as a valid flag and a source number. An interrupt handler can therefore read one word to learn which source to service. A single clock-control bit decides what may wake the core from idle: either any raw request, or only the enabled ones.

There is no acknowledge. A source stays pending for as long as its peripheral holds the request high. The design has no state machine: every output comes from a combinational function of the register contents and the requests, and is then captured in one flop stage.

Top module: `prio_intc`

## Requirements
- R1: After reset, the mask register, level register, clock-control bit and all priority entries read as zero. The irq_o, fiq_o and wake_o outputs are low, and the highest-priority register reads zero.
- R2: A read of word offset 0x000 returns src_req ANDed with the mask register. A mask bit of 1 enables its source.
- R3: The mask register (0x004), the level register (0x008) and bit 0 of the clock-control register (0x014) read back the last value written. All other clock-control bits read zero.
- R4: One clock after the inputs, irq_o is the OR of the enabled pending sources whose level bit is 0. fiq_o is the OR of the enabled pending sources whose level bit is 1.
- R5: Priority entry i lives at byte offset 0x01C + 4*i. Bit 31 holds its valid flag and bits 4:0 hold its source number. All other bits read zero.
- R6: The highest-priority register at 0x018 is scanned from entry 0 upward. It reports the source of the first entry that is valid and whose source is pending and enabled. Bit 31 is set and the source number sits in bits 30:16. Invalid entries are skipped, and the register reads zero when no entry qualifies. It reflects the inputs with one clock of latency.
- R7: wake_o is registered with one clock of latency. When clock-control bit 0 is 1, it is the OR of the enabled pending sources. When the bit is 0, it is the OR of the raw requests.
- R8: Writes to the pending register (0x000), the highest-priority register (0x018) and unmapped offsets change no register. Reads from unmapped offsets (0x00C, 0x010, and 0x09C upward) return zero.
- R9: A pending bit stays set while its request is held, and reading it does not clear it. It clears only when the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NSRC | Level requests from the peripherals |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Wake-from-idle request |

## Verification
The hardest case to reach from the ports is a search where the winner is not the first table entry. This happens when the early entries are invalid, point at masked sources, or name the same source more than once, while several requests are up together. The random stimulus fills table entries with random valid flags, draws their source numbers from a small pool so that duplicates are common, and keeps the requests sparse so that the winner moves around the table. Directed cases pin down a table with invalid and masked leading entries, and the all-invalid table.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // word-index map of the register space
    localparam int W_PEND  = 0;
    localparam int W_MASK  = 1;
    localparam int W_LEVEL = 2;
    localparam int W_CLK   = 5;
    localparam int W_HP    = 6;
    localparam int W_PRIO0 = 7;

    typedef enum logic [2:0] {
        RG_PEND,
        RG_MASK,
        RG_LEVEL,
        RG_CLK,
        RG_HP,
        RG_PRIO,
        RG_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input int word, input int nsrc);
        reg_sel_e r;
        if (word == W_PEND)                                   r = RG_PEND;
        else if (word == W_MASK)                              r = RG_MASK;
        else if (word == W_LEVEL)                             r = RG_LEVEL;
        else if (word == W_CLK)                               r = RG_CLK;
        else if (word == W_HP)                                r = RG_HP;
        else if (word >= W_PRIO0 && word < W_PRIO0 + nsrc)    r = RG_PRIO;
        else                                                  r = RG_NONE;
        return r;
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int SRC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [SRC_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    output logic [NSRC-1:0]  mask_q,
    output logic [NSRC-1:0]  level_q,
    output logic             gate_q,
    output logic [NSRC-1:0]  prio_vld,
    output logic [SRC_W-1:0] prio_src [NSRC]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            level_q <= '0;
            gate_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                RG_MASK:  mask_q  <= wr_data[NSRC-1:0];
                RG_LEVEL: level_q <= wr_data[NSRC-1:0];
                RG_CLK:   gate_q  <= wr_data[0];
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_vld[g] <= 1'b0;
                prio_src[g] <= '0;
            end else if (wr_en && wr_sel == RG_PRIO && int'(wr_idx) == g) begin
                prio_vld[g] <= wr_data[31];
                prio_src[g] <= wr_data[SRC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/intc_prio_search.sv
module intc_prio_search #(
    parameter int NSRC  = 32,
    parameter int SRC_W = 5
) (
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  prio_vld,
    input  logic [SRC_W-1:0] prio_src [NSRC],
    output logic             hit,
    output logic [SRC_W-1:0] hit_src
);

    logic [NSRC-1:0] qual;

    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        assign qual[g] = prio_vld[g] && (int'(prio_src[g]) < NSRC) && pend[prio_src[g]];
    end

    // descending walk so the lowest qualifying index is written last
    always_comb begin
        hit     = 1'b0;
        hit_src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (qual[i]) begin
                hit     = 1'b1;
                hit_src = prio_src[i];
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);

    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  level_q;
    logic             gate_q;
    logic [NSRC-1:0]  prio_vld;
    logic [SRC_W-1:0] prio_src [NSRC];

    logic [NSRC-1:0]  pend;
    logic             hit;
    logic [SRC_W-1:0] hit_src;

    logic             irq_q, fiq_q, wake_q;
    logic             hp_vld_q;
    logic [SRC_W-1:0] hp_src_q;

    int               word;
    reg_sel_e         sel;
    logic [SRC_W-1:0] ent_idx;

    assign word    = int'(bus_addr[ADDR_W-1:2]);
    assign sel     = decode_word(word, NSRC);
    assign ent_idx = SRC_W'(word - W_PRIO0);

    intc_regfile #(.NSRC(NSRC), .SRC_W(SRC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_sel && bus_we),
        .wr_sel   (sel),
        .wr_idx   (ent_idx),
        .wr_data  (bus_wdata),
        .mask_q   (mask_q),
        .level_q  (level_q),
        .gate_q   (gate_q),
        .prio_vld (prio_vld),
        .prio_src (prio_src)
    );

    assign pend = src_req & mask_q;

    intc_prio_search #(.NSRC(NSRC), .SRC_W(SRC_W)) u_search (
        .pend     (pend),
        .prio_vld (prio_vld),
        .prio_src (prio_src),
        .hit      (hit),
        .hit_src  (hit_src)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q    <= 1'b0;
            fiq_q    <= 1'b0;
            wake_q   <= 1'b0;
            hp_vld_q <= 1'b0;
            hp_src_q <= '0;
        end else begin
            irq_q    <= |(pend & ~level_q);
            fiq_q    <= |(pend & level_q);
            wake_q   <= gate_q ? |pend : |src_req;
            hp_vld_q <= hit;
            hp_src_q <= hit ? hit_src : '0;
        end
    end

    assign irq_o  = irq_q;
    assign fiq_o  = fiq_q;
    assign wake_o = wake_q;

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RG_PEND:  bus_rdata = 32'(pend);
            RG_MASK:  bus_rdata = 32'(mask_q);
            RG_LEVEL: bus_rdata = 32'(level_q);
            RG_CLK:   bus_rdata = {31'b0, gate_q};
            RG_HP:    bus_rdata = {hp_vld_q, 15'(hp_src_q), 16'b0};
            RG_PRIO:  bus_rdata = {prio_vld[ent_idx], 31'(prio_src[ent_idx])};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_req,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   level_q,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq_o,
    input logic              fiq_o,
    input logic              wake_o,
    input logic              hp_vld_q
);

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_req & mask_q & ~level_q) == '0) |=> !irq_o); // R4

    AST_FIQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_req & mask_q & level_q) == '0) |=> !fiq_o); // R4

    AST_HP_HAS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        hp_vld_q |-> (irq_o || fiq_o)); // R6

    AST_QUIET_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req == '0) |=> !wake_o); // R7

    AST_PEND_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr[ADDR_W-1:2] == '0) |=> ($stable(mask_q) && $stable(level_q))); // R8

endmodule

bind prio_intc intc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .mask_q   (mask_q),
    .level_q  (level_q),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .wake_o   (wake_o),
    .hp_vld_q (hp_vld_q)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o, wake_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit [31:0] m_mask, m_level;
    bit        m_gate;
    bit        m_pv [32];
    bit [4:0]  m_ps [32];

    always #2 clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (a[8:2] == 7'd1) m_mask = d;
        else if (a[8:2] == 7'd2) m_level = d;
        else if (a[8:2] == 7'd5) m_gate = d[0];
        else if (a[8:2] >= 7'd7 && a[8:2] < 7'd39) begin
            m_pv[a[8:2] - 7] = d[31];
            m_ps[a[8:2] - 7] = d[4:0];
        end
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic bit [31:0] exp_hp(input bit [31:0] req);
        bit [31:0] p = req & m_mask;
        for (int i = 0; i < 32; i++)
            if (m_pv[i] && p[m_ps[i]]) return {1'b1, 10'b0, m_ps[i], 16'b0};
        return 32'b0;
    endfunction

    // apply requests, let the output stage register them, then compare everything
    task automatic settle_and_check(input string tag, input logic [31:0] req);
        logic [31:0] rd;
        bit [31:0] p;
        src_req = req;
        @(posedge clk);
        @(negedge clk);
        p = req & m_mask;
        bus_read(9'h000, rd); chk("R2", {tag, " pending"}, rd, p);
        chk("R4", {tag, " irq"}, {31'b0, irq_o}, {31'b0, |(p & ~m_level)});
        chk("R4", {tag, " fiq"}, {31'b0, fiq_o}, {31'b0, |(p & m_level)});
        chk("R7", {tag, " wake"}, {31'b0, wake_o}, {31'b0, m_gate ? |p : |req});
        bus_read(9'h018, rd); chk("R6", {tag, " hp"}, rd, exp_hp(req));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] keep;
        void'($urandom(32'd2024));
        m_mask = '0; m_level = '0; m_gate = 0;
        for (int i = 0; i < 32; i++) begin m_pv[i] = 0; m_ps[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(9'h004, rd); chk("R1", "mask reset", rd, 0);
        bus_read(9'h008, rd); chk("R1", "level reset", rd, 0);
        bus_read(9'h014, rd); chk("R1", "clkctl reset", rd, 0);
        bus_read(9'h01C, rd); chk("R1", "prio0 reset", rd, 0);
        bus_read(9'h098, rd); chk("R1", "prio31 reset", rd, 0);
        bus_read(9'h018, rd); chk("R1", "hp reset", rd, 0);
        chk("R1", "lines reset", {29'b0, irq_o, fiq_o, wake_o}, 0);

        // R3 readback
        bus_write(9'h004, 32'hA5A5_0F0F); bus_read(9'h004, rd); chk("R3", "mask rb", rd, 32'hA5A5_0F0F);
        bus_write(9'h008, 32'h1234_5678); bus_read(9'h008, rd); chk("R3", "level rb", rd, 32'h1234_5678);
        bus_write(9'h014, 32'hFFFF_FFFF); bus_read(9'h014, rd); chk("R3", "clkctl rb", rd, 32'h1);
        bus_write(9'h014, 32'h0);

        // R5 priority entry format
        bus_write(9'h01C + 9'd12, 32'hFFFF_FFF3); bus_read(9'h028, rd); chk("R5", "prio3 fmt", rd, 32'h8000_0013);
        bus_write(9'h028, 32'h0000_0007); bus_read(9'h028, rd); chk("R5", "prio3 invalid", rd, 32'h0000_0007);

        // R8 ignored writes and unmapped reads
        bus_write(9'h000, 32'hFFFF_FFFF);
        bus_write(9'h018, 32'hFFFF_FFFF);
        bus_write(9'h00C, 32'hFFFF_FFFF);
        bus_write(9'h1FC, 32'hFFFF_FFFF);
        bus_read(9'h004, rd); chk("R8", "mask after ro writes", rd, 32'hA5A5_0F0F);
        bus_read(9'h008, rd); chk("R8", "level after ro writes", rd, 32'h1234_5678);
        bus_read(9'h014, rd); chk("R8", "clkctl after ro writes", rd, 32'h0);
        bus_read(9'h00C, rd); chk("R8", "unmapped 0x00C", rd, 0);
        bus_read(9'h010, rd); chk("R8", "unmapped 0x010", rd, 0);
        bus_read(9'h09C, rd); chk("R8", "unmapped 0x09C", rd, 0);
        bus_read(9'h1FC, rd); chk("R8", "unmapped 0x1FC", rd, 0);

        // R6 directed: leading entries invalid or masked, entry 2 wins
        bus_write(9'h004, 32'h0000_00F0);
        bus_write(9'h008, 32'h0000_0020);
        bus_write(9'h01C, 32'h0000_0004);          // entry0 invalid, src 4
        bus_write(9'h020, 32'h8000_0001);          // entry1 valid, src 1 (masked)
        bus_write(9'h024, 32'h8000_0005);          // entry2 valid, src 5
        bus_write(9'h028, 32'h8000_0004);          // entry3 valid, src 4
        settle_and_check("R6 skip-invalid", 32'h0000_0033);
        bus_read(9'h018, rd); chk("R6", "winner src5", rd, 32'h8005_0000);
        settle_and_check("R6 fall-through", 32'h0000_0013);
        bus_read(9'h018, rd); chk("R6", "winner src4", rd, 32'h8004_0000);
        settle_and_check("R6 none", 32'h0000_0003);
        bus_read(9'h018, rd); chk("R6", "no winner", rd, 32'h0);

        // R7 gating both ways with masked-only requests
        bus_write(9'h014, 32'h1);
        settle_and_check("R7 gated", 32'h0000_0001);
        chk("R7", "gated wake low", {31'b0, wake_o}, 0);
        bus_write(9'h014, 32'h0);
        settle_and_check("R7 ungated", 32'h0000_0001);
        chk("R7", "ungated wake high", {31'b0, wake_o}, 1);

        // R9 level behaviour
        settle_and_check("R9 hold", 32'h0000_0010);
        bus_read(9'h000, rd); chk("R9", "pending after read", rd, 32'h10);
        repeat (3) @(negedge clk);
        bus_read(9'h000, rd); chk("R9", "pending still held", rd, 32'h10);
        settle_and_check("R9 drop", 32'h0);
        bus_read(9'h000, rd); chk("R9", "pending cleared", rd, 32'h0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int k = $urandom % 6;
            if (k == 0) bus_write(9'h004, $urandom);
            else if (k == 1) bus_write(9'h008, $urandom);
            else if (k == 2) bus_write(9'h014, $urandom);
            else begin
                int e = $urandom % 32;
                keep = {($urandom % 3) != 0, 26'($urandom), 5'($urandom % 8)};
                bus_write(9'(9'h01C + e * 4), keep);
            end
            settle_and_check("rnd", ($urandom & $urandom & $urandom) | 32'($urandom % 8 == 0 ? 32'h0 : 32'h0));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule